// File: doc/BRIEF.md
# Sub-page coherence state controller

This block keeps the coherence state of every cached sub-page held by one node of a ring-connected shared-memory multiprocessor. Each entry of its state table stands for one 128-byte sub-page, the unit that is kept coherent and moved on the ring. The protocol works by invalidation and has four states: invalid, shared, exclusive and a lock state. The lock state gives the same ownership as exclusive, acts as a hardware lock, and is left only by an explicit unlock.

Two request streams reach the block. The local processor issues read, write, lock and unlock requests. With each request the ring side reports whether another node holds that sub-page locked. The ring also delivers requests snooped from other nodes, either reads or invalidates. Every accepted request updates its entry in one step. One cycle later the block returns a registered result. For a local request this is the success flag, the new state, an invalidate broadcast and an unlock-error flag. For a snoop it is a data-supply or refuse indication and the new state. Data storage, ring transport and address translation sit outside the block.

Top module: `sp_coh_ctrl`

## Requirements
- R1: After reset every entry is invalid (state code 0), and `l_done` and `s_done` are low. State codes are 0 invalid, 1 shared, 2 exclusive, 3 locked.
- R2: Local read (op code 0). On an invalid entry it succeeds and moves the entry to shared, but fails with no change when `lreq_remote_lock` is high. On a shared, exclusive or locked entry it succeeds and keeps the state.
- R3: Local write (op code 1). On an invalid or shared entry it moves the entry to exclusive and raises `l_inv`, but fails with no change when `lreq_remote_lock` is high. On an exclusive or locked entry it succeeds, keeps the state and raises no `l_inv`.
- R4: Lock (op code 2) on an entry that is not locked, with `lreq_remote_lock` low, succeeds and moves the entry to locked. `l_inv` is raised unless the entry was already exclusive.
- R5: Lock fails when the entry is already locked here or when `lreq_remote_lock` is high. A failed lock gives `l_ok` low, the state unchanged and no `l_inv`.
- R6: Unlock (op code 3) on a locked entry succeeds and moves it to exclusive.
- R7: Unlock on an entry that is not locked is ignored. The entry keeps its state, `l_ok` is low and `l_err` pulses for that one result.
- R8: Snooped read (snoop op 0). On an exclusive entry it raises `s_supply` and moves the entry to shared. On a locked entry it raises `s_refuse` and keeps the lock. On an invalid or shared entry it does nothing.
- R9: Snooped invalidate (snoop op 1). It moves a shared or exclusive entry to invalid. A locked entry keeps its state and raises `s_refuse`. An invalid entry stays invalid.
- R10: When a local request and a snoop name the same index in the same cycle, the snoop is taken and `lreq_ready` is low, so the local request is not accepted. With different indices both are accepted in the same cycle.
- R11: Each accepted request produces exactly one result one cycle later (`l_done`/`s_done`). The reported state is the state after the request, so a request to the same entry in the next cycle sees the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_op | input | 2 | Local operation: 0 read, 1 write, 2 lock, 3 unlock |
| lreq_idx | input | IW | Sub-page entry index of the local request |
| lreq_remote_lock | input | 1 | Ring reports the sub-page locked at another node |
| lreq_ready | output | 1 | Local request is accepted this cycle |
| snp_valid | input | 1 | Snooped request present |
| snp_op | input | 1 | Snoop operation: 0 read, 1 invalidate |
| snp_idx | input | IW | Sub-page entry index of the snoop |
| l_done | output | 1 | Local result valid |
| l_ok | output | 1 | Local request succeeded |
| l_state | output | 2 | Entry state after the local request |
| l_inv | output | 1 | Broadcast invalidate for the sub-page |
| l_err | output | 1 | Unlock issued on an entry that is not locked |
| s_done | output | 1 | Snoop result valid |
| s_supply | output | 1 | This node supplies the sub-page data |
| s_refuse | output | 1 | Snoop refused because the entry is locked |
| s_state | output | 2 | Entry state after the snoop |

## Verification
The assertions assume that the ring never raises `lreq_remote_lock` for a sub-page this node already owns, and that a refused or stalled local request is simply presented again by the requester. They also assume that inputs are known whenever a valid flag is high. The stimulus drives the remote-lock flag only for entries that the bench model holds as invalid or shared. It retries a stalled request in the following cycle and otherwise holds every valid flag low.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    CS_INV = 2'd0,
    CS_SHR = 2'd1,
    CS_EXC = 2'd2,
    CS_ATM = 2'd3
  } cstate_t;

  typedef enum logic [1:0] {
    LOP_READ   = 2'd0,
    LOP_WRITE  = 2'd1,
    LOP_LOCK   = 2'd2,
    LOP_UNLOCK = 2'd3
  } lop_t;

  typedef enum logic {
    SOP_READ = 1'b0,
    SOP_KILL = 1'b1
  } sop_t;

  typedef struct packed {
    logic    ok;
    logic    bcast_inv;
    logic    unlock_err;
    cstate_t nxt;
  } lres_t;

  typedef struct packed {
    logic    supply;
    logic    refuse;
    cstate_t nxt;
  } sres_t;

  // Transition for a request coming from this node's processor.
  function automatic lres_t local_step(cstate_t cur, lop_t op, logic rlock);
    lres_t r;
    r.ok         = 1'b1;
    r.bcast_inv  = 1'b0;
    r.unlock_err = 1'b0;
    r.nxt        = cur;
    case (op)
      LOP_READ: begin
        if (cur == CS_INV) begin
          if (rlock) r.ok = 1'b0;
          else       r.nxt = CS_SHR;
        end
      end
      LOP_WRITE: begin
        if (cur == CS_INV || cur == CS_SHR) begin
          if (rlock) r.ok = 1'b0;
          else begin
            r.nxt       = CS_EXC;
            r.bcast_inv = 1'b1;
          end
        end
      end
      LOP_LOCK: begin
        if (cur == CS_ATM || rlock) r.ok = 1'b0;
        else begin
          r.nxt       = CS_ATM;
          r.bcast_inv = (cur != CS_EXC);
        end
      end
      default: begin
        if (cur == CS_ATM) r.nxt = CS_EXC;
        else begin
          r.ok         = 1'b0;
          r.unlock_err = 1'b1;
        end
      end
    endcase
    return r;
  endfunction

  // Transition for a request snooped from another node.
  function automatic sres_t snoop_step(cstate_t cur, sop_t op);
    sres_t r;
    r.supply = 1'b0;
    r.refuse = 1'b0;
    r.nxt    = cur;
    if (cur == CS_ATM) begin
      r.refuse = 1'b1;
    end else if (op == SOP_READ) begin
      if (cur == CS_EXC) begin
        r.supply = 1'b1;
        r.nxt    = CS_SHR;
      end
    end else begin
      r.nxt = CS_INV;
    end
    return r;
  endfunction

endpackage

// File: rtl/spc_state_table.sv
module spc_state_table
  import spc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  output cstate_t       ra_state,
  input  logic [IW-1:0] rb_idx,
  output cstate_t       rb_state,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  cstate_t       wa_state,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  cstate_t       wb_state
);
  localparam int SW = $bits(cstate_t);

  logic [N_ENTRIES*SW-1:0] flat;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    cstate_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= CS_INV;
      else if (wa_en && wa_idx == IW'(e))      q <= wa_state;
      else if (wb_en && wb_idx == IW'(e))      q <= wb_state;
    end
    assign flat[e*SW +: SW] = q;
  end

  assign ra_state = cstate_t'(flat[ra_idx*SW +: SW]);
  assign rb_state = cstate_t'(flat[rb_idx*SW +: SW]);

endmodule

// File: rtl/spc_local_unit.sv
module spc_local_unit
  import spc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  lop_t    op,
  input  logic    rlock,
  input  cstate_t cur,
  output logic    wr_en,
  output cstate_t nxt,
  output logic    done,
  output logic    ok,
  output cstate_t state,
  output logic    bcast,
  output logic    err
);
  lres_t res;

  always_comb begin
    res   = local_step(cur, op, rlock);
    wr_en = fire;
    nxt   = res.nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      ok    <= 1'b0;
      state <= CS_INV;
      bcast <= 1'b0;
      err   <= 1'b0;
    end else begin
      done  <= fire;
      ok    <= fire & res.ok;
      state <= fire ? res.nxt : CS_INV;
      bcast <= fire & res.bcast_inv;
      err   <= fire & res.unlock_err;
    end
  end

endmodule

// File: rtl/spc_snoop_unit.sv
module spc_snoop_unit
  import spc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  sop_t    op,
  input  cstate_t cur,
  output logic    wr_en,
  output cstate_t nxt,
  output logic    done,
  output logic    supply,
  output logic    refuse,
  output cstate_t state
);
  sres_t res;

  always_comb begin
    res   = snoop_step(cur, op);
    wr_en = fire;
    nxt   = res.nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      supply <= 1'b0;
      refuse <= 1'b0;
      state  <= CS_INV;
    end else begin
      done   <= fire;
      supply <= fire & res.supply;
      refuse <= fire & res.refuse;
      state  <= fire ? res.nxt : CS_INV;
    end
  end

endmodule

// File: rtl/sp_coh_ctrl.sv
module sp_coh_ctrl
  import spc_pkg::*;
#(
  parameter  int N_ENTRIES = 8,
  localparam int IW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  input  logic [1:0]    lreq_op,
  input  logic [IW-1:0] lreq_idx,
  input  logic          lreq_remote_lock,
  output logic          lreq_ready,
  input  logic          snp_valid,
  input  logic          snp_op,
  input  logic [IW-1:0] snp_idx,
  output logic          l_done,
  output logic          l_ok,
  output logic [1:0]    l_state,
  output logic          l_inv,
  output logic          l_err,
  output logic          s_done,
  output logic          s_supply,
  output logic          s_refuse,
  output logic [1:0]    s_state
);
  // Named internal events, brought out for the checker.
  logic    idx_clash;
  logic    loc_fire;
  logic    snp_fire;
  cstate_t loc_cur;
  cstate_t snp_cur;
  cstate_t loc_nxt;
  cstate_t snp_nxt;
  logic    loc_wr;
  logic    snp_wr;
  cstate_t l_state_e;
  cstate_t s_state_e;

  // A snoop to the same sub-page wins; the local request waits a cycle.
  assign idx_clash  = snp_valid && (snp_idx == lreq_idx);
  assign lreq_ready = !idx_clash;
  assign loc_fire   = lreq_valid && lreq_ready;
  assign snp_fire   = snp_valid;

  spc_state_table #(.N_ENTRIES(N_ENTRIES), .IW(IW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_idx   (lreq_idx),
    .ra_state (loc_cur),
    .rb_idx   (snp_idx),
    .rb_state (snp_cur),
    .wa_en    (loc_wr),
    .wa_idx   (lreq_idx),
    .wa_state (loc_nxt),
    .wb_en    (snp_wr),
    .wb_idx   (snp_idx),
    .wb_state (snp_nxt)
  );

  spc_local_unit u_loc (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (loc_fire),
    .op    (lop_t'(lreq_op)),
    .rlock (lreq_remote_lock),
    .cur   (loc_cur),
    .wr_en (loc_wr),
    .nxt   (loc_nxt),
    .done  (l_done),
    .ok    (l_ok),
    .state (l_state_e),
    .bcast (l_inv),
    .err   (l_err)
  );

  spc_snoop_unit u_snp (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (snp_fire),
    .op     (sop_t'(snp_op)),
    .cur    (snp_cur),
    .wr_en  (snp_wr),
    .nxt    (snp_nxt),
    .done   (s_done),
    .supply (s_supply),
    .refuse (s_refuse),
    .state  (s_state_e)
  );

  assign l_state = l_state_e;
  assign s_state = s_state_e;

endmodule

module spc_checker
  import spc_pkg::*;
#(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loc_fire,
  input logic          snp_fire,
  input logic [1:0]    lreq_op,
  input logic [IW-1:0] lreq_idx,
  input logic          lreq_remote_lock,
  input logic          snp_op,
  input logic [IW-1:0] snp_idx,
  input logic [1:0]    loc_cur,
  input logic [1:0]    snp_cur,
  input logic          l_done,
  input logic          l_ok,
  input logic [1:0]    l_state,
  input logic          l_inv,
  input logic          l_err,
  input logic          s_done,
  input logic          s_supply,
  input logic          s_refuse,
  input logic [1:0]    s_state
);

  a_r10_no_same_index: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_fire && snp_fire) |-> (lreq_idx != snp_idx));

  a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    loc_fire |=> l_done);

  a_r11_snoop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    snp_fire |=> s_done);

  a_r5_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_fire && lreq_op == LOP_LOCK && loc_cur == CS_ATM)
      |=> (!l_ok && l_state == CS_ATM && !l_inv));

  a_r4_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_fire && lreq_op == LOP_LOCK && loc_cur != CS_ATM && !lreq_remote_lock)
      |=> (l_ok && l_state == CS_ATM && (l_inv == ($past(loc_cur) != CS_EXC))));

  a_r3_bcast_owner: assert property (@(posedge clk) disable iff (!rst_n)
    l_inv |-> (l_ok && (l_state == CS_EXC || l_state == CS_ATM)));

  a_r7_err_fails: assert property (@(posedge clk) disable iff (!rst_n)
    l_err |-> (l_done && !l_ok));

  a_r8_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_fire && snp_op == SOP_READ && snp_cur == CS_EXC)
      |=> (s_supply && s_state == CS_SHR));

  a_r9_lock_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_fire && snp_cur == CS_ATM) |=> (s_refuse && !s_supply && s_state == CS_ATM));

endmodule

bind sp_coh_ctrl spc_checker #(.IW(IW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .loc_fire         (loc_fire),
  .snp_fire         (snp_fire),
  .lreq_op          (lreq_op),
  .lreq_idx         (lreq_idx),
  .lreq_remote_lock (lreq_remote_lock),
  .snp_op           (snp_op),
  .snp_idx          (snp_idx),
  .loc_cur          (loc_cur),
  .snp_cur          (snp_cur),
  .l_done           (l_done),
  .l_ok             (l_ok),
  .l_state          (l_state),
  .l_inv            (l_inv),
  .l_err            (l_err),
  .s_done           (s_done),
  .s_supply         (s_supply),
  .s_refuse         (s_refuse),
  .s_state          (s_state)
);

// File: tb/sp_coh_ctrl_test.sv
module sp_coh_ctrl_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lreq_valid = 1'b0;
  logic [1:0]    lreq_op = 2'd0;
  logic [IW-1:0] lreq_idx = '0;
  logic          lreq_remote_lock = 1'b0;
  logic          lreq_ready;
  logic          snp_valid = 1'b0;
  logic          snp_op = 1'b0;
  logic [IW-1:0] snp_idx = '0;
  logic          l_done, l_ok, l_inv, l_err;
  logic [1:0]    l_state;
  logic          s_done, s_supply, s_refuse;
  logic [1:0]    s_state;

  always #2 clk = ~clk;

  sp_coh_ctrl #(.N_ENTRIES(N)) uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic       ok;
    logic       inv;
    logic       err;
    logic [1:0] st;
    string      tag;
  } lexp_t;

  typedef struct {
    logic       sup;
    logic       refu;
    logic [1:0] st;
    string      tag;
  } sexp_t;

  lexp_t lq[$];
  sexp_t sq[$];
  logic [1:0] mdl [N];

  task automatic note(bit good, string tag, string what, int act, int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Codes from the requirements: states 0 inv,1 shr,2 exc,3 locked.
  function automatic lexp_t ref_loc(logic [1:0] c, logic [1:0] op, logic rl, string tag);
    lexp_t e;
    e.tag = tag; e.ok = 1; e.inv = 0; e.err = 0; e.st = c;
    if (op == 2'd3) begin
      if (c == 2'd3) e.st = 2'd2;
      else begin e.ok = 0; e.err = 1; end
    end else if (op == 2'd2) begin
      if (c == 2'd3 || rl) e.ok = 0;
      else begin e.st = 2'd3; e.inv = (c != 2'd2); end
    end else if (op == 2'd1) begin
      if (c < 2'd2) begin
        if (rl) e.ok = 0;
        else begin e.st = 2'd2; e.inv = 1; end
      end
    end else begin
      if (c == 2'd0) begin
        if (rl) e.ok = 0;
        else e.st = 2'd1;
      end
    end
    return e;
  endfunction

  function automatic sexp_t ref_snp(logic [1:0] c, logic op, string tag);
    sexp_t e;
    e.tag = tag; e.sup = 0; e.refu = 0; e.st = c;
    if (c == 2'd3) e.refu = 1;
    else if (op == 1'b1) e.st = 2'd0;
    else if (c == 2'd2) begin e.sup = 1; e.st = 2'd1; end
    return e;
  endfunction

  // Driver: presents one cycle of stimulus and queues the expected results.
  task automatic step(bit lv, logic [1:0] lop, int li, bit rl,
                      bit sv, bit sop, int si, string tag);
    bit    exp_rdy;
    lexp_t le;
    sexp_t se;
    @(negedge clk);
    lreq_valid = lv; lreq_op = lop; lreq_idx = IW'(li); lreq_remote_lock = rl;
    snp_valid = sv; snp_op = sop; snp_idx = IW'(si);
    #1;
    exp_rdy = !(sv && si == li);
    if (lv) note(lreq_ready == exp_rdy, (sv && si == li) ? "R10" : tag,
                 "lreq_ready", int'(lreq_ready), int'(exp_rdy));
    if (sv) begin
      se = ref_snp(mdl[si], sop, tag);
      mdl[si] = se.st;
      sq.push_back(se);
    end
    if (lv && exp_rdy) begin
      le = ref_loc(mdl[li], lop, rl, tag);
      mdl[li] = le.st;
      lq.push_back(le);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      lreq_valid = 0; snp_valid = 0; lreq_remote_lock = 0;
    end
  endtask

  // Monitor: compares each result as it appears, one cycle after acceptance.
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (lq.size() > 0) begin
        lexp_t e;
        e = lq.pop_front();
        note({l_done, l_ok, l_inv, l_err, l_state} == {1'b1, e.ok, e.inv, e.err, e.st},
             e.tag, "local {done,ok,inv,err,state}",
             int'({l_done, l_ok, l_inv, l_err, l_state}),
             int'({1'b1, e.ok, e.inv, e.err, e.st}));
      end else if (l_done) begin
        note(0, "R11", "unexpected l_done", 1, 0);
      end
      if (sq.size() > 0) begin
        sexp_t e;
        e = sq.pop_front();
        note({s_done, s_supply, s_refuse, s_state} == {1'b1, e.sup, e.refu, e.st},
             e.tag, "snoop {done,supply,refuse,state}",
             int'({s_done, s_supply, s_refuse, s_state}),
             int'({1'b1, e.sup, e.refu, e.st}));
      end else if (s_done) begin
        note(0, "R11", "unexpected s_done", 1, 0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 2'd0;
    repeat (3) @(negedge clk);
    note(l_done == 0 && s_done == 0, "R1", "done flags in reset",
         int'({l_done, s_done}), 0);
    rst_n = 1'b1;
    // R1: every entry reads back invalid through a snooped read
    for (int i = 0; i < N; i++) step(0, 0, 0, 0, 1, 0, i, "R1");

    // R2: local reads
    step(1, 2'd0, 0, 0, 0, 0, 0, "R2");
    step(1, 2'd0, 0, 0, 0, 0, 0, "R2");
    step(1, 2'd0, 1, 1, 0, 0, 0, "R2");
    // R3: local writes
    step(1, 2'd1, 0, 0, 0, 0, 0, "R3");
    step(1, 2'd1, 0, 0, 0, 0, 0, "R3");
    step(1, 2'd1, 2, 1, 0, 0, 0, "R3");
    step(1, 2'd1, 2, 0, 0, 0, 0, "R3");
    // R4: lock from exclusive and from invalid
    step(1, 2'd2, 0, 0, 0, 0, 0, "R4");
    step(1, 2'd2, 3, 0, 0, 0, 0, "R4");
    // R5: lock refused (held here, held remotely)
    step(1, 2'd2, 0, 0, 0, 0, 0, "R5");
    step(1, 2'd2, 4, 1, 0, 0, 0, "R5");
    // R7: unlock on entries that are not locked; state checked by a later read
    step(1, 2'd3, 4, 0, 0, 0, 0, "R7");
    step(1, 2'd3, 2, 0, 0, 0, 0, "R7");
    step(1, 2'd0, 2, 0, 0, 0, 0, "R7");
    // R8: snooped reads
    step(0, 0, 0, 0, 1, 0, 2, "R8");
    step(0, 0, 0, 0, 1, 0, 3, "R8");
    step(0, 0, 0, 0, 1, 0, 2, "R8");
    // R9: snooped invalidates
    step(0, 0, 0, 0, 1, 1, 3, "R9");
    step(0, 0, 0, 0, 1, 1, 2, "R9");
    step(1, 2'd1, 5, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 1, 5, "R9");
    step(0, 0, 0, 0, 1, 1, 4, "R9");
    // R6: unlock of locked entries
    step(1, 2'd3, 3, 0, 0, 0, 0, "R6");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 3, "R6");
    // R10: same-index clash stalls local; retry; different indices proceed together
    step(1, 2'd1, 6, 0, 1, 0, 6, "R10");
    step(1, 2'd1, 6, 0, 0, 0, 0, "R10");
    step(1, 2'd2, 7, 0, 1, 1, 0, "R10");
    step(1, 2'd0, 6, 0, 1, 0, 7, "R10");
    // R11: back-to-back requests to one entry observe each other's updates
    step(1, 2'd1, 1, 0, 0, 0, 0, "R11");
    step(1, 2'd2, 1, 0, 0, 0, 0, "R11");
    step(1, 2'd3, 1, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 1, 0, 1, "R11");
    idle(3);
    note(lq.size() == 0 && sq.size() == 0, "R11", "pending results",
         lq.size() + sq.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule